// File: doc/BRIEF.md
# Serial Save-Memory Command Responder

This block is the device side of a byte-serial save memory. A host pushes one byte per strobe together with a hold flag. While hold stays high the bytes belong to one transaction. The first held byte of a transaction is taken as the command, and the bytes after it carry an address or act as dummy clocks for returned data. After each strobe the block presents one reply byte, which the host collects with its next exchange.

The responder decodes five commands:

| Code | Command |
|------|---------|
| 0x03 | Memory read |
| 0x04 | Write-enable clear |
| 0x05 | Status read |
| 0x06 | Write-enable set |
| 0x9F | Identification read |

The memory read takes a parameterised number of big-endian address bytes and then streams bytes from an internal array. Addresses past the end of the array read as zero. Any other command code is flagged as an error.

A backdoor write port fills the array, for example from a saved image at start-up. The block does no programming, erase or busy timing.

Top module: `save_mem_responder`

## Requirements
- R1: After reset `dataOut` is 0x00 and `cmdError` is low. The status register is 0x00, and a status read as the first transaction returns 0x00.
- R2: A strobed byte with `holdIn` high, when the previous strobed byte had `holdIn` low (or none has arrived since reset), becomes the current command. That strobe clears `dataOut` to 0x00 and clears the address and the byte position.
- R3: A strobed byte with `holdIn` low is still processed under the current command. It also ends the transaction, so the next strobed byte with `holdIn` high starts a new command.
- R4: Command 0x03 works in two phases. The next ADDR_BYTES bytes are shifted into the address, most significant first, and each of them replies 0x00. Every later byte replies mem[addr] and then increments the address, modulo 2^(8*ADDR_BYTES).
- R5: A read at an address greater than or equal to MEM_BYTES replies 0x00. The address still increments.
- R6: Command 0x06 sets status bit 1 (write enable), and command 0x04 clears it. Every byte under either command replies 0x00.
- R7: Every byte under command 0x05 replies with the status register. Only bit 1 of the status register can ever be set.
- R8: Every byte under command 0x9F replies 0xFF.
- R9: A byte under any other command code leaves `dataOut` unchanged. It also raises `cmdError` for exactly the one cycle after the strobe. A command byte itself never raises the flag.
- R10: `dataOut` changes only in the cycle after a strobe. With `byteValid` low it holds its value.
- R11: A cycle with `loadEn` high writes `loadData` into mem[`loadAddr`].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Strobe: one host byte this cycle |
| byteIn | input | 8 | Host byte |
| holdIn | input | 1 | Transaction hold (chip-select active) |
| dataOut | output | 8 | Reply byte, updated the cycle after a strobe |
| cmdError | output | 1 | One-cycle pulse for a byte under an unknown command |
| loadEn | input | 1 | Backdoor array write enable |
| loadAddr | input | IDX_W | Backdoor array write address |
| loadData | input | 8 | Backdoor array write data |

## Verification
The bench builds the block with MEM_BYTES = 256 and ADDR_BYTES = 2. With these values the whole array can be swept in one read burst. The same burst runs 44 bytes past the end of the array, so the zero-reply region above 0x00FF is reached. A start address of 0xFFFE brings the 16-bit address wrap within a few bytes.

A small array also makes it cheap to sweep all 256 command codes. Each code is checked for its reply byte, its error flag and its effect on the status register.

// File: rtl/save_mem_pkg.sv
package save_mem_pkg;

  localparam logic [7:0] CMD_READ   = 8'h03;
  localparam logic [7:0] CMD_WRDIS  = 8'h04;
  localparam logic [7:0] CMD_STATUS = 8'h05;
  localparam logic [7:0] CMD_WREN   = 8'h06;
  localparam logic [7:0] CMD_IDENT  = 8'h9F;

  localparam logic [7:0] IDENT_BYTE = 8'hFF;
  localparam int         WE_BIT     = 1;

  typedef struct packed {
    logic latchCmd;
    logic shiftAddr;
    logic readMem;
    logic setWe;
    logic clrWe;
    logic readStatus;
    logic readId;
    logic badCmd;
  } strobe_t;

endpackage

// File: rtl/save_mem_ctrl.sv
module save_mem_ctrl
  import save_mem_pkg::*;
#(
  parameter int ADDR_BYTES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic [7:0] byteIn,
  input  logic       holdIn,
  output strobe_t    strb
);

  localparam int POS_MAX = ADDR_BYTES + 1;
  localparam int POS_W   = $clog2(POS_MAX + 1);

  logic             heldQ;
  logic [7:0]       cmdQ;
  logic [POS_W-1:0] posQ;

  always_comb begin
    strb = '0;
    if (byteValid) begin
      if (holdIn && !heldQ) begin
        strb.latchCmd = 1'b1;
      end else begin
        unique case (cmdQ)
          CMD_READ: begin
            if (posQ < POS_W'(POS_MAX)) strb.shiftAddr = 1'b1;
            else                        strb.readMem   = 1'b1;
          end
          CMD_WRDIS:  strb.clrWe      = 1'b1;
          CMD_STATUS: strb.readStatus = 1'b1;
          CMD_WREN:   strb.setWe      = 1'b1;
          CMD_IDENT:  strb.readId     = 1'b1;
          default:    strb.badCmd     = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldQ <= 1'b0;
      cmdQ  <= '0;
      posQ  <= '0;
    end else if (byteValid) begin
      heldQ <= holdIn;
      if (strb.latchCmd) begin
        cmdQ <= byteIn;
        posQ <= POS_W'(1);
      end else if (strb.shiftAddr) begin
        posQ <= posQ + POS_W'(1);
      end
    end
  end

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  // R2
  latch_sets_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchCmd |=> heldQ && (posQ == POS_W'(1)));

  // R3
  release_clears_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !holdIn) |=> !heldQ);

  // R4
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    posQ <= POS_W'(POS_MAX));

endmodule

// File: rtl/save_mem_datapath.sv
module save_mem_datapath
  import save_mem_pkg::*;
#(
  parameter int MEM_BYTES  = 1024,
  parameter int ADDR_BYTES = 2,
  localparam int IDX_W     = $clog2(MEM_BYTES),
  localparam int ADDR_W    = 8 * ADDR_BYTES
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [7:0]       byteIn,
  input  logic             loadEn,
  input  logic [IDX_W-1:0] loadAddr,
  input  logic [7:0]       loadData,
  output logic [7:0]       dataOut,
  output logic             cmdError
);

  logic [7:0]        mem [MEM_BYTES];
  logic [ADDR_W-1:0] addrQ;
  logic [7:0]        outQ;
  logic [7:0]        statusQ;
  logic              errQ;
  logic              inRange;
  logic [7:0]        memByte;

  assign inRange = (ADDR_W'(addrQ) < ADDR_W'(MEM_BYTES));
  assign memByte = inRange ? mem[addrQ[IDX_W-1:0]] : 8'h00;

  always_ff @(posedge clk) begin
    if (loadEn) mem[loadAddr] <= loadData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      outQ    <= '0;
      statusQ <= '0;
      errQ    <= 1'b0;
    end else begin
      errQ <= strb.badCmd;
      if (strb.latchCmd) begin
        addrQ <= '0;
        outQ  <= 8'h00;
      end
      if (strb.shiftAddr) begin
        addrQ <= (addrQ << 8) | ADDR_W'(byteIn);
        outQ  <= 8'h00;
      end
      if (strb.readMem) begin
        outQ  <= memByte;
        addrQ <= addrQ + ADDR_W'(1);
      end
      if (strb.setWe) begin
        statusQ[WE_BIT] <= 1'b1;
        outQ            <= 8'h00;
      end
      if (strb.clrWe) begin
        statusQ[WE_BIT] <= 1'b0;
        outQ            <= 8'h00;
      end
      if (strb.readStatus) outQ <= statusQ;
      if (strb.readId)     outQ <= IDENT_BYTE;
    end
  end

  assign dataOut  = outQ;
  assign cmdError = errQ;

  // R2
  latch_clears_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchCmd |=> (outQ == 8'h00) && (addrQ == '0));

  // R5
  out_of_range_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.readMem && !inRange) |=> (outQ == 8'h00));

  // R4
  read_advances_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.readMem |=> (addrQ == $past(addrQ) + ADDR_W'(1)));

  // R6
  we_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setWe |=> statusQ[WE_BIT] && (outQ == 8'h00));

  // R6
  we_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrWe |=> !statusQ[WE_BIT] && (outQ == 8'h00));

  // R7
  status_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & ~(8'h01 << WE_BIT)) == 8'h00);

  // R8
  ident_reply_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.readId |=> (outQ == 8'hFF));

  // R9
  bad_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.badCmd |=> $stable(outQ) && errQ);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> $stable(outQ) && !errQ);

endmodule

// File: rtl/save_mem_responder.sv
module save_mem_responder
  import save_mem_pkg::*;
#(
  parameter int MEM_BYTES  = 1024,
  parameter int ADDR_BYTES = 2,
  localparam int IDX_W     = $clog2(MEM_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteValid,
  input  logic [7:0]       byteIn,
  input  logic             holdIn,
  output logic [7:0]       dataOut,
  output logic             cmdError,
  input  logic             loadEn,
  input  logic [IDX_W-1:0] loadAddr,
  input  logic [7:0]       loadData
);

  strobe_t strb;

  save_mem_ctrl #(
    .ADDR_BYTES(ADDR_BYTES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .byteValid(byteValid),
    .byteIn   (byteIn),
    .holdIn   (holdIn),
    .strb     (strb)
  );

  save_mem_datapath #(
    .MEM_BYTES (MEM_BYTES),
    .ADDR_BYTES(ADDR_BYTES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .byteIn  (byteIn),
    .loadEn  (loadEn),
    .loadAddr(loadAddr),
    .loadData(loadData),
    .dataOut (dataOut),
    .cmdError(cmdError)
  );

endmodule

// File: tb/save_mem_responder_tb.sv
`timescale 1ns/1ps
module save_mem_responder_tb;

  localparam int MEM_BYTES  = 256;
  localparam int ADDR_BYTES = 2;
  localparam int IDX_W      = $clog2(MEM_BYTES);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             byteValid = 1'b0;
  logic [7:0]       byteIn = '0;
  logic             holdIn = 1'b0;
  logic [7:0]       dataOut;
  logic             cmdError;
  logic             loadEn = 1'b0;
  logic [IDX_W-1:0] loadAddr = '0;
  logic [7:0]       loadData = '0;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  save_mem_responder #(
    .MEM_BYTES (MEM_BYTES),
    .ADDR_BYTES(ADDR_BYTES)
  ) u_dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteIn(byteIn),
    .holdIn(holdIn), .dataOut(dataOut), .cmdError(cmdError),
    .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] memExp(int a);
    int w = a & 16'hFFFF;
    return (w < MEM_BYTES) ? pat(w) : 8'h00;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // one strobed byte; returns reply and error flag seen one cycle later
  task automatic xfer(input logic [7:0] b, input logic h,
                      output logic [7:0] r, output logic e);
    @(negedge clk);
    byteIn = b; holdIn = h; byteValid = 1'b1;
    @(negedge clk);
    byteValid = 1'b0;
    r = dataOut;
    e = cmdError;
  endtask

  task automatic readRun(int start, int count, string tag);
    logic [7:0] r;
    logic e;
    xfer(8'h03, 1'b1, r, e);
    chk({tag, " R2 latch reply"}, r, 8'h00);
    xfer(8'((start >> 8) & 255), 1'b1, r, e);
    chk({tag, " R4 addr hi reply"}, r, 8'h00);
    xfer(8'(start & 255), 1'b1, r, e);
    chk({tag, " R4 addr lo reply"}, r, 8'h00);
    for (int k = 0; k < count; k++) begin
      xfer(8'h00, (k != count - 1), r, e);
      chk({tag, ((start + k) & 16'hFFFF) >= MEM_BYTES ? " R5 beyond" : " R4 data"},
          r, memExp(start + k));
      chk({tag, " R9 no error on read"}, {7'b0, e}, 8'h00);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      misses++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r;
    logic e;
    logic [7:0] expStatus;
    logic [7:0] expOut;
    logic expErr;

    repeat (3) @(negedge clk);
    // R11 preload through the backdoor
    for (int i = 0; i < MEM_BYTES; i++) begin
      loadEn = 1'b1; loadAddr = IDX_W'(i); loadData = pat(i);
      @(negedge clk);
    end
    loadEn = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    chk("R1 reset dataOut", dataOut, 8'h00);
    chk("R1 reset cmdError", {7'b0, cmdError}, 8'h00);

    // R1 first transaction reads status zero
    xfer(8'h05, 1'b1, r, e);
    xfer(8'h00, 1'b0, r, e);
    chk("R1 R7 status after reset", r, 8'h00);

    // R4 R5 R11 full sweep from 0, running past the array end
    readRun(0, MEM_BYTES + 44, "sweep");

    // R4 R5 assorted start addresses including 16-bit wrap
    readRun(16'h00F0, 4, "startF0");
    readRun(16'h00FE, 4, "startFE");
    readRun(16'h0100, 4, "start100");
    readRun(16'h1234, 4, "start1234");
    readRun(16'hFFFE, 4, "wrap");

    // R3 new command after release: ident
    xfer(8'h9F, 1'b1, r, e);
    chk("R3 new command latched, reply cleared", r, 8'h00);
    xfer(8'h12, 1'b1, r, e);
    chk("R8 ident reply", r, 8'hFF);
    xfer(8'h34, 1'b0, r, e);
    chk("R3 R8 released byte still processed", r, 8'hFF);

    // R10 idle cycles hold dataOut
    repeat (5) @(negedge clk);
    chk("R10 idle hold", dataOut, 8'hFF);
    chk("R10 idle no error", {7'b0, cmdError}, 8'h00);

    // R6 R7 write enable set / clear
    xfer(8'h06, 1'b1, r, e);
    xfer(8'h00, 1'b0, r, e);
    chk("R6 wren reply", r, 8'h00);
    xfer(8'h05, 1'b1, r, e);
    xfer(8'h00, 1'b1, r, e);
    chk("R7 status with we", r, 8'h02);
    xfer(8'h00, 1'b0, r, e);
    chk("R7 status repeat", r, 8'h02);
    xfer(8'h04, 1'b1, r, e);
    xfer(8'h00, 1'b0, r, e);
    chk("R6 wrdis reply", r, 8'h00);
    xfer(8'h05, 1'b1, r, e);
    xfer(8'h00, 1'b0, r, e);
    chk("R7 status cleared", r, 8'h00);

    // R9 error pulse lasts one cycle
    xfer(8'h5A, 1'b1, r, e);
    chk("R9 command byte no error", {7'b0, e}, 8'h00);
    xfer(8'h77, 1'b1, r, e);
    chk("R9 unknown reply unchanged", r, 8'h00);
    chk("R9 unknown error raised", {7'b0, e}, 8'h01);
    @(negedge clk);
    chk("R9 error drops after one cycle", {7'b0, cmdError}, 8'h00);
    xfer(8'h00, 1'b0, r, e);

    // R2 R6 R7 R8 R9 exhaustive command sweep
    expStatus = 8'h00;
    for (int c = 0; c < 256; c++) begin
      xfer(8'(c), 1'b1, r, e);
      chk("R2 latch clears reply", r, 8'h00);
      chk("R9 latch no error", {7'b0, e}, 8'h00);
      expErr = 1'b0;
      case (8'(c))
        8'h03:   expOut = 8'h00;
        8'h04:   begin expStatus = 8'h00; expOut = 8'h00; end
        8'h06:   begin expStatus = 8'h02; expOut = 8'h00; end
        8'h05:   expOut = expStatus;
        8'h9F:   expOut = 8'hFF;
        default: begin expOut = 8'h00; expErr = 1'b1; end
      endcase
      xfer(8'hA5, 1'b1, r, e);
      chk("R6 R7 R8 R9 sweep reply held", r, expOut);
      chk("R9 sweep error held", {7'b0, e}, {7'b0, expErr});
      xfer(8'hA5, 1'b0, r, e);
      chk("R3 sweep reply released", r, expOut);
      chk("R9 sweep error released", {7'b0, e}, {7'b0, expErr});
    end
    xfer(8'h05, 1'b1, r, e);
    xfer(8'h00, 1'b0, r, e);
    chk("R7 status after sweep", r, expStatus);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule